// File: doc/BRIEF.md
# Two-Space I2C Register Target with Wrapping Pointer

This block is the serial front end of a small timekeeping-style register file. It sits on an I2C bus as a target. It takes the raw SCL and SDA levels, synchronises them to the system clock, and pulls SDA low through an open-drain enable when it needs to send a zero. The block answers to two 7-bit device addresses. One selects a 20-byte control/status space (word addresses 00h to 13h). The other selects a 64-byte user SRAM space. Both spaces share one word-address pointer.

A master can do four kinds of transfer:
- a single-byte write: identification byte, word address, data;
- a current-address read that starts at the pointer;
- a random read: a dummy write that loads the pointer, then a repeated START and a read identification byte;
- a sequential read that keeps returning bytes while the master acknowledges.

Each space wraps the pointer at its own top address. While the battery-mode input is high, the block leaves the bus alone and keeps the stored contents.

Top module: `i2c_regslave`

## Requirements
- R1: An identification byte is acknowledged only when its upper 7 bits are 1101111 (control/status space) or 1010111 (SRAM space). Bit 0 of the byte is R/W, with 1 meaning read. Any other address leaves SDA released on the ninth clock.
- R2: After reset, SDA is released, the pointer is 00h and every register reads 00h. A current-address read issued before any word address therefore returns the byte at 00h.
- R3: A write is an identification byte with R/W=0, one word-address byte that loads the pointer, and one data byte. All three are acknowledged. The data is stored at the pointer in the space named by the identification byte. The write leaves the pointer unchanged.
- R4: After the data byte of a write, the block goes idle. Further bytes before the next START are not acknowledged and not stored.
- R5: In a random read, the block acknowledges the write identification byte, the word address and the read identification byte that follows a repeated START. It then returns the addressed byte, MSB first.
- R6: If the read identification byte after a dummy write names a different space than the dummy write did, it is not acknowledged.
- R7: The pointer advances by one after each byte sent. Sending continues while the master acknowledges. A master NACK releases SDA until the next START, and the next current-address read continues at the following location.
- R8: In the control/status space, the pointer steps from 13h to 00h during a sequential read.
- R9: The SRAM space holds 64 bytes, and its pointer steps from 3Fh to 00h.
- R10: A write to a control/status address above 13h is acknowledged but not stored. A read from such an address returns 00h.
- R11: While battery mode is high, SDA stays released, no address is acknowledged, nothing is written, and stored contents survive.
- R12: A START or STOP (an SDA edge while SCL is high) abandons any byte in progress. A partial data byte is not stored.
- R13: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| batt_mode | input | 1 | High disables the serial interface |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The SDA drive responds 3 system clocks after an SCL edge on the pins: two synchroniser flops, then the control register. The bench waits 5 clocks after each SCL edge before it changes SDA, and samples the bus in the middle of the SCL-high phase, so every acknowledge bit and every data bit has settled before it is read. Stored data is checked only in a later read transaction, never in the cycle of the write. The SDA-drive timing of R13 is watched on every clock by a monitor that flags any change of the drive while SCL is high.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
    localparam int PTR_W = 8;
    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RXDONE, ST_ACK, ST_TX, ST_MACK, ST_TXLD
    } st_e;

    typedef enum logic [1:0] {
        K_ID, K_WADR, K_WDATA
    } kind_e;

    typedef struct packed {
        st_e        st;
        kind_e      kind;
        logic [2:0] cnt;
        logic [7:0] sr;
        ptr_t       ptr;
        logic       sram;
        logic       rd;
        logic       dum_vld;
        logic       dum_sram;
        logic       oe;
    } ctl_t;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_p;
        logic [STAGES-1:0] sda_p;
        logic              scl_l;
        logic              sda_l;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d       = sy_q;
        sy_d.scl_p = {sy_q.scl_p[STAGES-2:0], scl_in};
        sy_d.sda_p = {sy_q.sda_p[STAGES-2:0], sda_in};
        sy_d.scl_l = sy_q.scl_p[STAGES-1];
        sy_d.sda_l = sy_q.sda_p[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    assign scl_s     = sy_q.scl_p[STAGES-1];
    assign sda_s     = sy_q.sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~sy_q.scl_l;
    assign scl_fall  = ~scl_s & sy_q.scl_l;
    assign start_det = scl_s & sy_q.scl_l & sy_q.sda_l & ~sda_s;
    assign stop_det  = scl_s & sy_q.scl_l & ~sy_q.sda_l & sda_s;
endmodule

// File: rtl/i2c_rs_regfile.sv
module i2c_rs_regfile
    import i2c_rs_pkg::*;
#(
    parameter int CSR_LAST   = 19,
    parameter int SRAM_DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       sel_sram,
    input  ptr_t       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int   CSR_DEPTH  = CSR_LAST + 1;
    localparam int   CSR_AW     = $clog2(CSR_DEPTH);
    localparam int   SRAM_AW    = $clog2(SRAM_DEPTH);
    localparam ptr_t CSR_LAST_P = ptr_t'(CSR_LAST);

    logic [7:0] csr_mem  [CSR_DEPTH];
    logic [7:0] sram_mem [SRAM_DEPTH];
    logic       csr_ok;

    assign csr_ok = (addr <= CSR_LAST_P);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CSR_DEPTH; i++)  csr_mem[i]  <= '0;
            for (int j = 0; j < SRAM_DEPTH; j++) sram_mem[j] <= '0;
        end else if (we) begin
            if (sel_sram)    sram_mem[addr[SRAM_AW-1:0]] <= wdata;
            else if (csr_ok) csr_mem[addr[CSR_AW-1:0]]   <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_sram)    rdata = sram_mem[addr[SRAM_AW-1:0]];
        else if (csr_ok) rdata = csr_mem[addr[CSR_AW-1:0]];
    end
endmodule

// File: rtl/i2c_rs_ctrl.sv
module i2c_rs_ctrl
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] CSR_ID     = 7'b1101111,
    parameter logic [6:0] SRAM_ID    = 7'b1010111,
    parameter int         CSR_LAST   = 19,
    parameter int         SRAM_DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       batt_mode,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rdata,
    output logic       sda_oe,
    output ptr_t       ptr,
    output logic       sram_sel,
    output logic       we,
    output logic [7:0] wdata,
    output logic       adr_ld
);
    localparam ptr_t CSR_LAST_P = ptr_t'(CSR_LAST);
    localparam ptr_t SRAM_MASK  = ptr_t'(SRAM_DEPTH - 1);

    ctl_t       c_d, c_q;
    logic [6:0] id_w;
    logic       id_is_sram;
    logic       id_hit;

    function automatic ptr_t ptr_next(input ptr_t p, input logic in_sram);
        if (in_sram)              return (p + ptr_t'(1)) & SRAM_MASK;
        else if (p == CSR_LAST_P) return '0;
        else                      return p + ptr_t'(1);
    endfunction

    assign id_w       = c_q.sr[7:1];
    assign id_is_sram = (id_w == SRAM_ID);
    assign id_hit     = ((id_w == CSR_ID) || id_is_sram) &&
                        !(c_q.dum_vld && (id_is_sram != c_q.dum_sram));

    always_comb begin
        c_d    = c_q;
        we     = 1'b0;
        adr_ld = 1'b0;
        if (batt_mode) begin
            c_d.st      = ST_IDLE;
            c_d.oe      = 1'b0;
            c_d.dum_vld = 1'b0;
        end else if (stop_det) begin
            c_d.st      = ST_IDLE;
            c_d.oe      = 1'b0;
            c_d.dum_vld = 1'b0;
        end else if (start_det) begin
            c_d.st   = ST_RX;
            c_d.kind = K_ID;
            c_d.cnt  = '0;
            c_d.oe   = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_IDLE: ;
                ST_RX: if (scl_rise) begin
                    c_d.sr = {c_q.sr[6:0], sda_s};
                    if (c_q.cnt == 3'd7) c_d.st  = ST_RXDONE;
                    else                 c_d.cnt = c_q.cnt + 3'd1;
                end
                ST_RXDONE: if (scl_fall) begin
                    unique case (c_q.kind)
                        K_ID: begin
                            if (id_hit) begin
                                c_d.oe   = 1'b1;
                                c_d.st   = ST_ACK;
                                c_d.sram = id_is_sram;
                                c_d.rd   = c_q.sr[0];
                            end else begin
                                c_d.st = ST_IDLE;
                            end
                        end
                        K_WADR: begin
                            c_d.oe       = 1'b1;
                            c_d.st       = ST_ACK;
                            c_d.ptr      = c_q.sr;
                            c_d.dum_vld  = 1'b1;
                            c_d.dum_sram = c_q.sram;
                            adr_ld       = 1'b1;
                        end
                        default: begin
                            c_d.oe = 1'b1;
                            c_d.st = ST_ACK;
                            we     = 1'b1;
                        end
                    endcase
                end
                ST_ACK: if (scl_fall) begin
                    c_d.oe  = 1'b0;
                    c_d.cnt = '0;
                    unique case (c_q.kind)
                        K_ID: begin
                            if (c_q.rd) begin
                                c_d.sr = rdata;
                                c_d.oe = ~rdata[7];
                                c_d.st = ST_TX;
                            end else begin
                                c_d.st   = ST_RX;
                                c_d.kind = K_WADR;
                            end
                        end
                        K_WADR: begin
                            c_d.st   = ST_RX;
                            c_d.kind = K_WDATA;
                        end
                        default: c_d.st = ST_IDLE;
                    endcase
                end
                ST_TX: if (scl_fall) begin
                    if (c_q.cnt == 3'd7) begin
                        c_d.oe  = 1'b0;
                        c_d.st  = ST_MACK;
                        c_d.ptr = ptr_next(c_q.ptr, c_q.sram);
                    end else begin
                        c_d.sr  = {c_q.sr[6:0], 1'b0};
                        c_d.oe  = ~c_q.sr[6];
                        c_d.cnt = c_q.cnt + 3'd1;
                    end
                end
                ST_MACK: if (scl_rise) begin
                    c_d.st = sda_s ? ST_IDLE : ST_TXLD;
                end
                ST_TXLD: if (scl_fall) begin
                    c_d.sr  = rdata;
                    c_d.oe  = ~rdata[7];
                    c_d.cnt = '0;
                    c_d.st  = ST_TX;
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
            c_q.kind <= K_ID;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe   = c_q.oe;
    assign ptr      = c_q.ptr;
    assign sram_sel = c_q.sram;
    assign wdata    = c_q.sr;
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] CSR_ID      = 7'b1101111,
    parameter logic [6:0] SRAM_ID     = 7'b1010111,
    parameter int         CSR_LAST    = 19,
    parameter int         SRAM_DEPTH  = 64,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic batt_mode,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    ptr_t       ptr;
    logic       sram_sel, we, adr_ld;
    logic [7:0] wdata, rdata;

    i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rs_ctrl #(
        .CSR_ID(CSR_ID), .SRAM_ID(SRAM_ID),
        .CSR_LAST(CSR_LAST), .SRAM_DEPTH(SRAM_DEPTH)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .batt_mode(batt_mode), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rdata(rdata), .sda_oe(sda_oe), .ptr(ptr),
        .sram_sel(sram_sel), .we(we), .wdata(wdata), .adr_ld(adr_ld)
    );

    i2c_rs_regfile #(.CSR_LAST(CSR_LAST), .SRAM_DEPTH(SRAM_DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .sel_sram(sram_sel),
        .addr(ptr), .wdata(wdata), .rdata(rdata)
    );
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk #(
    parameter int CSR_LAST   = 19,
    parameter int SRAM_DEPTH = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       batt_mode,
    input logic       sda_oe,
    input logic       scl_s,
    input logic [7:0] ptr,
    input logic       sram_sel,
    input logic       adr_ld,
    input logic       we
);
    assert_sda_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !batt_mode && !$past(batt_mode)) |-> !scl_s);

    assert_batt_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        batt_mode |=> !sda_oe);

    assert_batt_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        batt_mode |-> !we);

    assert_write_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> sda_oe);

    assert_csr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ptr) == 8'(CSR_LAST) && !$past(sram_sel) && !$past(adr_ld) &&
         ptr != $past(ptr)) |-> ptr == 8'h00);

    assert_sram_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ptr) == 8'(SRAM_DEPTH - 1) && $past(sram_sel) && !$past(adr_ld) &&
         ptr != $past(ptr)) |-> ptr == 8'h00);
endmodule

bind i2c_regslave i2c_regslave_chk #(.CSR_LAST(CSR_LAST), .SRAM_DEPTH(SRAM_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .batt_mode(batt_mode), .sda_oe(sda_oe),
    .scl_s(scl_s), .ptr(ptr), .sram_sel(sram_sel), .adr_ld(adr_ld), .we(we)
);

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;
    localparam logic [6:0] CSR  = 7'b1101111;
    localparam logic [6:0] SRAM = 7'b1010111;
    localparam int Q = 5;
    localparam int NV = 6;
    // each vector: {device id, word address, data}
    localparam logic [22:0] VEC [NV] = '{
        {CSR, 8'h00, 8'hA5}, {CSR, 8'h07, 8'h3C}, {CSR, 8'h13, 8'h81},
        {SRAM, 8'h00, 8'h5A}, {SRAM, 8'h21, 8'hC3}, {SRAM, 8'h3F, 8'h96}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic batt = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   n_chk = 0;
    int   n_bad = 0;
    int   r13_bad = 0;
    logic oe_prev = 1'b0;
    logic [7:0] got [4];
    logic [2:0] nk;
    logic       b;

    always #2 clk = ~clk;
    assign sda_bus = msda & ~sda_oe;

    i2c_regslave dut (
        .clk(clk), .rst_n(rst_n), .batt_mode(batt),
        .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe)
    );

    // R13 monitor: drive may only move while SCL is low
    always @(negedge clk) begin
        if (rst_n && !batt && scl && (sda_oe !== oe_prev)) r13_bad++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic i_start();
        msda = 1'b0; wq(1); scl = 1'b0; wq(1);
    endtask

    task automatic i_rstart();
        msda = 1'b1; wq(1); scl = 1'b1; wq(1); msda = 1'b0; wq(1); scl = 1'b0; wq(1);
    endtask

    task automatic i_stop();
        msda = 1'b0; wq(1); scl = 1'b1; wq(1); msda = 1'b1; wq(1);
    endtask

    task automatic send_bits(input logic [7:0] v, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            wq(1); msda = v[i]; wq(1); scl = 1'b1; wq(2); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output logic nack);
        send_bits(v, 8);
        wq(1); msda = 1'b1; wq(1); scl = 1'b1; wq(1); nack = sda_bus; wq(1); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            wq(1); msda = 1'b1; wq(1); scl = 1'b1; wq(1); v[i] = sda_bus; wq(1); scl = 1'b0;
        end
        wq(1); msda = ~ack; wq(1); scl = 1'b1; wq(2); scl = 1'b0;
    endtask

    task automatic wr(input logic [6:0] id, input logic [7:0] a, input logic [7:0] d,
                      output logic [2:0] n);
        i_start();
        send_byte({id, 1'b0}, n[0]);
        send_byte(a, n[1]);
        send_byte(d, n[2]);
        i_stop();
    endtask

    task automatic rd_rand(input logic [6:0] id, input logic [7:0] a, input int cnt,
                           output logic [2:0] n);
        i_start();
        send_byte({id, 1'b0}, n[0]);
        send_byte(a, n[1]);
        i_rstart();
        send_byte({id, 1'b1}, n[2]);
        if (n == 3'b000)
            for (int i = 0; i < cnt; i++) recv_byte(i != cnt - 1, got[i]);
        i_stop();
    endtask

    task automatic rd_cur(input logic [6:0] id, input int cnt, output logic n);
        i_start();
        send_byte({id, 1'b1}, n);
        if (!n)
            for (int i = 0; i < cnt; i++) recv_byte(i != cnt - 1, got[i]);
        i_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1..all actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        chk("R2 reset drive", sda_oe, 1'b0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R2 drive after reset", sda_oe, 1'b0);

        // R2: current-address read right after reset starts at 00h
        rd_cur(CSR, 2, b);
        chk("R2 ack", b, 1'b0);
        chk("R2 byte00", got[0], 8'h00);
        chk("R2 byte01", got[1], 8'h00);

        // R3/R5 vector walk
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][22:16], VEC[v][15:8], VEC[v][7:0], nk);
            chk($sformatf("R3 write acks vec%0d", v), nk, 3'b000);
            rd_rand(VEC[v][22:16], VEC[v][15:8], 1, nk);
            chk($sformatf("R5 read acks vec%0d", v), nk, 3'b000);
            chk($sformatf("R5 read data vec%0d", v), got[0], VEC[v][7:0]);
        end

        // R9: pointer left at 00h after the SRAM 3Fh read
        rd_cur(SRAM, 1, b);
        chk("R9 wrap cur ack", b, 1'b0);
        chk("R9 wrap cur data", got[0], 8'h5A);
        rd_rand(SRAM, 8'h3F, 2, nk);
        chk("R9 seq b0", got[0], 8'h96);
        chk("R9 seq b1", got[1], 8'h5A);

        // R8: control/status wrap 13h -> 00h
        rd_rand(CSR, 8'h12, 3, nk);
        chk("R8 b12", got[0], 8'h00);
        chk("R8 b13", got[1], 8'h81);
        chk("R8 b00", got[2], 8'hA5);

        // R7: NACK releases bus, pointer continues
        i_start();
        send_byte({CSR, 1'b0}, nk[0]);
        send_byte(8'h06, nk[1]);
        i_rstart();
        send_byte({CSR, 1'b1}, nk[2]);
        recv_byte(1'b0, got[0]);
        recv_byte(1'b0, got[1]);
        i_stop();
        chk("R7 acks", nk, 3'b000);
        chk("R7 data06", got[0], 8'h00);
        chk("R7 released after nack", got[1], 8'hFF);
        rd_cur(CSR, 1, b);
        chk("R7 continue at 07", got[0], 8'h3C);

        // R1: foreign addresses
        wr(7'h50, 8'h01, 8'h11, nk);
        chk("R1 foreign nack", nk, 3'b111);
        wr(7'b1101110, 8'h01, 8'h11, nk);
        chk("R1 near-miss nack", nk, 3'b111);
        rd_rand(CSR, 8'h01, 1, nk);
        chk("R1 no store", got[0], 8'h00);

        // R6: dummy write and read name different spaces
        i_start();
        send_byte({CSR, 1'b0}, nk[0]);
        send_byte(8'h05, nk[1]);
        i_rstart();
        send_byte({SRAM, 1'b1}, nk[2]);
        i_stop();
        chk("R6 mismatch nack", nk, 3'b100);

        // R4: second data byte refused
        i_start();
        send_byte({SRAM, 1'b0}, nk[0]);
        send_byte(8'h10, nk[1]);
        send_byte(8'h11, nk[2]);
        send_byte(8'h22, b);
        i_stop();
        chk("R4 first acks", nk, 3'b000);
        chk("R4 extra nack", b, 1'b1);
        rd_rand(SRAM, 8'h10, 2, nk);
        chk("R4 stored", got[0], 8'h11);
        chk("R4 next untouched", got[1], 8'h00);

        // R10: control/status address above 13h
        wr(CSR, 8'h14, 8'hEE, nk);
        chk("R10 acks", nk, 3'b000);
        rd_rand(CSR, 8'h14, 1, nk);
        chk("R10 read zero", got[0], 8'h00);

        // R11: battery mode
        batt = 1'b1;
        wq(4);
        wr(SRAM, 8'h20, 8'h77, nk);
        chk("R11 nack in batt", nk, 3'b111);
        chk("R11 released", sda_oe, 1'b0);
        batt = 1'b0;
        wq(4);
        rd_rand(SRAM, 8'h21, 1, nk);
        chk("R11 kept", got[0], 8'hC3);
        rd_rand(SRAM, 8'h20, 1, nk);
        chk("R11 no write", got[0], 8'h00);

        // R12: STOP inside a data byte
        i_start();
        send_byte({CSR, 1'b0}, nk[0]);
        send_byte(8'h02, nk[1]);
        send_bits(8'hF0, 4);
        i_stop();
        rd_rand(CSR, 8'h02, 1, nk);
        chk("R12 partial not stored", got[0], 8'h00);
        wr(CSR, 8'h02, 8'h44, nk);
        rd_rand(CSR, 8'h02, 1, nk);
        chk("R12 next write works", got[0], 8'h44);

        chk("R13 drive moved with SCL high", r13_bad, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule